// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Transceiver

This block joins an asynchronous serial receiver and transmitter that run on the same clock. One bit period, given in clock cycles, comes in on a single divisor input. The top level forwards that value to both halves, so it has exactly one driver and both directions always run at the same rate. Frames carry one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line is high when idle.

The receiver passes the line through a two-flop synchronizer and finds the falling edge of a start bit. It samples each bit at the middle of its period. A good frame puts the word on `rx_data` and raises `rx_ready`. The word stays there until the consumer pulses `rx_ack`. A frame whose stop bit reads low sets `rx_frame_err` and delivers no word. A good frame that completes while an earlier word is still waiting is dropped and sets `rx_overrun`.

The transmitter takes `tx_data` on a cycle where `tx_ack` is high and it is not busy. It shifts the frame out on `tx_line` and pulses `tx_done` for one cycle once the stop bit has lasted a full period.

Top module: `uart_xcvr`

## Requirements
- R1: After reset `tx_line` is 1, and `tx_busy`, `tx_done`, `rx_ready`, `rx_busy`, `rx_frame_err`, `rx_overrun` and `rx_data` are all 0.
- R2: A frame on either line is a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit. `tx_line` is 1 whenever `tx_busy` is 0.
- R3: Every bit lasts `divisor` clock cycles on both halves. `divisor` must be at least 4 and must not change during a frame.
- R4: The RX line goes through two flops. A 0 seen after them starts a frame. The start bit is checked again `divisor/2` (rounded down) cycles later. If it reads 1 there, the receiver goes back to idle and delivers nothing. Each later bit is sampled `divisor` cycles after the one before it.
- R5: `rx_ready` rises on the cycle after a good stop bit is sampled, with the word on `rx_data`. Both stay unchanged until a clock edge at which `rx_ready` and `rx_ack` are both high; after that edge `rx_ready` is 0.
- R6: If the stop bit is sampled as 0, `rx_frame_err` becomes 1 and no word is delivered. The receiver then waits for the synchronized line to return to 1 before it looks for a new start bit. `rx_frame_err` clears when the next start bit is detected.
- R7: If a good frame completes while `rx_ready` is 1 and `rx_ack` is 0, the new word is dropped, `rx_data` keeps the old word and `rx_overrun` becomes 1. `rx_overrun` clears at the same edge that consumes the waiting word.
- R8: `rx_busy` is 1 from the cycle after a start bit is detected until the frame ends. After a framing error it stays 1 until the line has returned high.
- R9: The transmitter captures `tx_data` and starts a frame on an edge where `tx_ack` is 1 and `tx_busy` is 0. While `tx_busy` is 1, `tx_ack` and `tx_data` are ignored.
- R10: `tx_done` is a one-cycle pulse `10*divisor` cycles after the accepting edge. `tx_busy` falls at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| divisor | input | DIV_W | Bit period in clock cycles, shared by both halves |
| rx_line | input | 1 | Serial input, asynchronous to clk |
| rx_ack | input | 1 | Consumer accepts the waiting received word |
| rx_data | output | DATA_W | Received word |
| rx_ready | output | 1 | A received word is waiting |
| rx_busy | output | 1 | Reception in progress |
| rx_frame_err | output | 1 | Last frame had a low stop bit |
| rx_overrun | output | 1 | A good frame was dropped because the last word was not yet taken |
| tx_data | input | DATA_W | Word offered for transmission |
| tx_ack | input | 1 | Start sending `tx_data` when idle |
| tx_line | output | 1 | Serial output, high when idle |
| tx_busy | output | 1 | Transmission in progress |
| tx_done | output | 1 | One-cycle pulse when the stop bit has completed |

## Verification
Most internal faults in this block show up at the ports within one bit period. A bit counter that is off by one shifts every later `tx_line` transition, and a reference that is compared on every cycle catches this at the first misplaced edge. It also moves the `tx_done` pulse by a multiple of `divisor`. A wrong receive sampling point or shift direction shows up when `rx_ready` rises: `rx_data` differs from the word that was sent. A stale handshake state shows up as `rx_ready` or `rx_overrun` at the wrong level on the cycle after an `rx_ack` edge. Stimulus covers even and odd divisors, all-zero and all-one words, a start-bit glitch, a low stop bit and back-to-back frames with no acknowledgement.

// File: rtl/uart_xcvr_pkg.sv
// Shared types for the serial transceiver.
// Assumes: one clock domain for both halves.
package uart_xcvr_pkg;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_HOLD  = 3'd4
    } rx_state_t;

    typedef enum logic [0:0] {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_t;

endpackage

// File: rtl/uart_xcvr_sync.sv
// Multi-flop synchronizer for an asynchronous level input.
// Assumes: the input idles high, so every stage resets to 1.
module uart_xcvr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // single stage: capture directly
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= din;
            end
        end else begin : g_many
            // shift the line through the stage chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_xcvr_rx.sv
// Receiver half: finds the start edge on the synchronized line and
// samples each bit at mid-period. It checks the stop bit and holds the
// word under a ready/ack handshake.
// Assumes: divisor >= 4 and stable during a frame.
module uart_xcvr_rx
    import uart_xcvr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              line_s,
    input  logic              ack,
    output logic [DATA_W-1:0] data,
    output logic              ready,
    output logic              busy,
    output logic              frame_err,
    output logic              overrun
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    rx_state_t         state;
    logic [DIV_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic [DIV_W-1:0]  half_m1;
    logic [DIV_W-1:0]  full_m1;
    logic              tick;
    logic              word_done;
    logic              take;

    assign half_m1   = (divisor >> 1) - 1'b1;
    assign full_m1   = divisor - 1'b1;
    assign tick      = (cnt == '0);
    assign word_done = (state == RX_STOP) && tick && line_s;
    assign take      = ready && ack;
    assign busy      = (state != RX_IDLE);

    // frame sequencer: start check, data shift, stop check, error hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            frame_err <= 1'b0;
        end else begin
            case (state)
                RX_IDLE: begin
                    if (!line_s) begin
                        state     <= RX_START;
                        cnt       <= half_m1;
                        frame_err <= 1'b0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (!line_s) begin
                            state <= RX_DATA;
                            cnt   <= full_m1;
                            idx   <= '0;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        shreg <= {line_s, shreg[DATA_W-1:1]};
                        cnt   <= full_m1;
                        if (idx == LAST_IDX) state <= RX_STOP;
                        else                 idx   <= idx + 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (line_s) begin
                            state <= RX_IDLE;
                        end else begin
                            state     <= RX_HOLD;
                            frame_err <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (line_s) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // downstream handshake: hold word until taken, flag dropped words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data    <= '0;
            ready   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (take) begin
                ready   <= 1'b0;
                overrun <= 1'b0;
            end
            if (word_done) begin
                if (ready && !ack) begin
                    overrun <= 1'b1;
                end else begin
                    data  <= shreg;
                    ready <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_xcvr_tx.sv
// Transmitter half: on an accepted ack it captures the word and drives
// start, data (LSB first) and stop. It pulses done when the stop bit
// has lasted one full period.
// Assumes: divisor >= 4 and stable during a frame.
module uart_xcvr_tx
    import uart_xcvr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [DATA_W-1:0] data,
    input  logic              ack,
    output logic              line,
    output logic              busy,
    output logic              done
);
    localparam int POS_W = $clog2(DATA_W + 2);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(DATA_W + 1);

    tx_state_t         state;
    logic [DIV_W-1:0]  cnt;
    logic [POS_W-1:0]  pos;
    logic [DATA_W:0]   frame;

    assign busy = (state == TX_SHIFT);

    // bit sequencer: load on ack when idle, step every divisor cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            pos   <= '0;
            frame <= '1;
            line  <= 1'b1;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (ack) begin
                        state <= TX_SHIFT;
                        frame <= {1'b1, data};
                        line  <= 1'b0;
                        cnt   <= divisor - 1'b1;
                        pos   <= '0;
                    end
                end
                TX_SHIFT: begin
                    if (cnt == '0) begin
                        cnt <= divisor - 1'b1;
                        if (pos == LAST_POS) begin
                            state <= TX_IDLE;
                            done  <= 1'b1;
                        end else begin
                            pos   <= pos + 1'b1;
                            line  <= frame[0];
                            frame <= {1'b1, frame[DATA_W:1]};
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_xcvr.sv
// Transceiver top: one synchronizer, a receiver and a transmitter.
// A single divisor net, driven here, times both halves.
// Assumes: divisor >= 4 and changed only while both halves are idle.
module uart_xcvr #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              rx_line,
    input  logic              rx_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              rx_busy,
    output logic              rx_frame_err,
    output logic              rx_overrun,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_ack,
    output logic              tx_line,
    output logic              tx_busy,
    output logic              tx_done
);
    logic [DIV_W-1:0] bit_div;
    logic             rx_line_s;

    // single driver of the shared bit period
    assign bit_div = divisor;

    uart_xcvr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (rx_line_s)
    );

    uart_xcvr_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .divisor  (bit_div),
        .line_s   (rx_line_s),
        .ack      (rx_ack),
        .data     (rx_data),
        .ready    (rx_ready),
        .busy     (rx_busy),
        .frame_err(rx_frame_err),
        .overrun  (rx_overrun)
    );

    uart_xcvr_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .divisor(bit_div),
        .data   (tx_data),
        .ack    (tx_ack),
        .line   (tx_line),
        .busy   (tx_busy),
        .done   (tx_done)
    );
endmodule

// File: rtl/uart_xcvr_chk.sv
// Port-level protocol checker for the transceiver, bound to the top.
module uart_xcvr_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_ack,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ready,
    input logic              rx_overrun,
    input logic              tx_ack,
    input logic              tx_line,
    input logic              tx_busy,
    input logic              tx_done
);
    assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !tx_line);

    assert_ready_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rx_ack) |=> (rx_ready && $stable(rx_data)));

    assert_overrun_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_ready));

    assert_start_needs_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(tx_ack));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!tx_busy && $past(tx_busy)));
endmodule

bind uart_xcvr uart_xcvr_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/uart_xcvr_bench.sv
module uart_xcvr_bench;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  divisor = 16'd8;
    logic              rx_line = 1'b1;
    logic              rx_ack = 1'b0;
    logic [DATA_W-1:0] rx_data;
    logic              rx_ready, rx_busy, rx_frame_err, rx_overrun;
    logic [DATA_W-1:0] tx_data = '0;
    logic              tx_ack = 1'b0;
    logic              tx_line, tx_busy, tx_done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    uart_xcvr #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_uart_xcvr (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_d1, m_d2;
    int  r_ph, r_wait;
    logic [7:0] r_byte;
    int  m_rdy, m_dat, m_ferr, m_ovr, m_rbusy;
    int  t_t, t_busy, t_done, t_line;
    logic [7:0] t_byte;
    bit  model_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_d1 = 1; m_d2 = 1; r_ph = -1; r_wait = 0; r_byte = 0;
            m_rdy = 0; m_dat = 0; m_ferr = 0; m_ovr = 0; m_rbusy = 0;
            t_t = 0; t_busy = 0; t_done = 0; t_line = 1; t_byte = 0;
            model_on = 1;
        end else begin
            int  d;
            int  seen;
            bit  deliver;
            bit  taken;
            d = int'(divisor);
            // receive side
            seen = m_d2; m_d2 = m_d1; m_d1 = int'(rx_line);
            deliver = 0;
            taken = (m_rdy == 1) && rx_ack;
            if (r_ph == -1) begin
                if (seen == 0) begin r_ph = 0; r_wait = d / 2 - 1; m_ferr = 0; end
            end else if (r_ph == 10) begin
                if (seen == 1) r_ph = -1;
            end else if (r_wait > 0) begin
                r_wait--;
            end else if (r_ph == 0) begin
                if (seen == 0) begin r_ph = 1; r_wait = d - 1; end
                else r_ph = -1;
            end else if (r_ph <= 8) begin
                r_byte[r_ph-1] = seen[0]; r_ph++; r_wait = d - 1;
            end else begin
                if (seen == 1) begin deliver = 1; r_ph = -1; end
                else begin m_ferr = 1; r_ph = 10; end
            end
            if (taken) begin m_rdy = 0; m_ovr = 0; end
            if (deliver) begin
                if (m_rdy == 1) m_ovr = 1;
                else begin m_dat = r_byte; m_rdy = 1; end
            end
            m_rbusy = (r_ph != -1);
            // transmit side
            t_done = 0;
            if (t_busy == 0) begin
                if (tx_ack) begin t_busy = 1; t_t = 0; t_byte = tx_data; t_line = 0; end
            end else begin
                t_t++;
                if (t_t == 10 * d) begin t_busy = 0; t_done = 1; t_line = 1; end
                else if (t_t < d) t_line = 0;
                else if (t_t < 9 * d) t_line = int'(t_byte[t_t / d - 1]);
                else t_line = 1;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            check("R5 rx_ready", rx_ready, m_rdy);
            check("R4 rx_data",  rx_data, m_dat);
            check("R6 rx_frame_err", rx_frame_err, m_ferr);
            check("R7 rx_overrun", rx_overrun, m_ovr);
            check("R8 rx_busy", rx_busy, m_rbusy);
            check("R2 tx_line", tx_line, t_line);
            check("R9 tx_busy", tx_busy, t_busy);
            check("R10 tx_done", tx_done, t_done);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic rx_frame(input logic [7:0] b, input logic stop);
        int d;
        d = int'(divisor);
        rx_line = 1'b0; tick(d);
        for (int i = 0; i < 8; i++) begin rx_line = b[i]; tick(d); end
        rx_line = stop; tick(d);
    endtask

    task automatic tx_send(input logic [7:0] b);
        tx_data = b; tx_ack = 1'b1; tick(1); tx_ack = 1'b0;
        while (!tx_done) tick(1);
        tick(1);
    endtask

    task automatic rx_take(input logic [7:0] exp, input string tag);
        int guard;
        guard = 0;
        while (!rx_ready && guard < 200) begin tick(1); guard++; end
        check({tag, " word"}, rx_data, exp);
        rx_ack = 1'b1; tick(1); rx_ack = 1'b0;
        check("R5 ready cleared after ack", rx_ready, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 tx_line", tx_line, 1);
        check("R1 tx_busy", tx_busy, 0);
        check("R1 rx_ready", rx_ready, 0);
        check("R1 rx_data", rx_data, 0);
        check("R1 rx_frame_err", rx_frame_err, 0);
        check("R1 rx_overrun", rx_overrun, 0);

        // R2 R3 full duplex at divisor 8
        fork
            tx_send(8'hA5);
            rx_frame(8'h3C, 1'b1);
        join
        tick(2);
        rx_take(8'h3C, "R2");

        // R9 ack and data ignored while busy
        tx_data = 8'h4E; tx_ack = 1'b1; tick(1);
        tx_data = 8'hFF; tick(20); tx_ack = 1'b0;
        while (!tx_done) tick(1);
        tick(3);
        check("R9 no restart after ignored ack", tx_busy, 0);

        // R7 overrun: two frames, no ack
        rx_frame(8'h11, 1'b1);
        tick(4);
        rx_frame(8'h22, 1'b1);
        tick(6);
        check("R7 overrun set", rx_overrun, 1);
        check("R7 old word kept", rx_data, 8'h11);
        rx_take(8'h11, "R7");
        check("R7 overrun cleared", rx_overrun, 0);

        // R6 low stop bit, line held low then released
        rx_frame(8'h5A, 1'b0);
        tick(3 * int'(divisor));
        check("R8 busy while line low after error", rx_busy, 1);
        rx_line = 1'b1;
        tick(2 * int'(divisor));
        check("R6 frame error set", rx_frame_err, 1);
        check("R6 no word", rx_ready, 0);
        rx_frame(8'hC3, 1'b1);
        tick(4);
        check("R6 error cleared by new start", rx_frame_err, 0);
        rx_take(8'hC3, "R6");

        // R4 start glitch rejected
        rx_line = 1'b0; tick(2); rx_line = 1'b1;
        tick(3 * int'(divisor));
        check("R4 glitch gives no word", rx_ready, 0);
        check("R4 glitch back to idle", rx_busy, 0);

        // R3 odd divisor, boundary words
        divisor = 16'd5;
        tick(2);
        fork
            tx_send(8'h81);
            rx_frame(8'h00, 1'b1);
        join
        tick(2);
        rx_take(8'h00, "R3");
        fork
            tx_send(8'h7F);
            rx_frame(8'hFF, 1'b1);
        join
        tick(2);
        rx_take(8'hFF, "R3");
        tick(10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule